// File: doc/BRIEF.md
# Windowed Watchdog Timer

This peripheral guards a system against stalled software. A 12-bit down-counter advances once for every PRESCALE pulses of a slow-clock enable. With the default PRESCALE of 128 and a 32.768 kHz slow clock, that is one step every 1/256 s, so the longest period is 4096 steps, or 16 s. Software restarts the counter with a keyed command. A restart is honoured only while the count has fallen to or below a programmable window threshold. A restart that arrives too early is flagged as an error. If the counter steps past zero, that is flagged as an underflow. Either event can raise a sticky reset request.

The configuration word is write-once. Only the first write after reset is taken. It sets the reload value in steps, the window threshold, reset enable, freeze-on-debug and a stop bit. A reload of N steps gives an underflow after N+1 steps. A timeout of s seconds is therefore written as s*256-1.

The registers sit on a simple strobe bus. There are three word addresses: the command word at 0x0, the configuration word at 0x4 and the status word at 0x8.

Top module: `wwdt_core`

## Requirements
- R1: After reset the count is 0xFFF. The configuration reads 0x01FFFFFF: reload 0xFFF in [11:0], window 0xFFF in [23:12], reset enable in bit 24, debug-freeze clear in bit 25, stop clear in bit 26. Status reads 0x0FFF0000, with flags clear. `rst_req` and `wdt_err` are low.
- R2: While running, the count drops by one on every PRESCALE-th `slow_en` pulse. Fewer pulses leave it unchanged.
- R3: A step taken at count 0 is an underflow. It reloads the count with the reload value and sets status bit 0. If reset enable is set, it raises `rst_req`, which then stays high until `rst_n` is asserted.
- R4: The first configuration write after reset is stored. It loads the count with the new reload value and clears the prescaler. Every later configuration write is ignored.
- R5: A command write with 0xA5 in [31:24] and bit 0 set is a restart. When the count is at or below the window, the restart reloads the count and clears the prescaler. This includes the case where the count equals the window, and any count when the window is 0xFFF.
- R6: A command write with any other key, or with bit 0 clear, changes nothing.
- R7: A restart while the count is above the window does not reload. It sets status bit 1 and, with reset enable set, raises `rst_req`.
- R8: With the debug-freeze bit set, neither the count nor the prescaler moves while `dbg_halt` is high.
- R9: With the stop bit set, the counter never moves, never underflows and never requests a reset.
- R10: A status read returns the flags in [1:0] and the count in [27:16] on `rd_data` one cycle after the strobe. The read clears both flags. `wdt_err` is the OR of the two flags.
- R11: With reset enable clear, an underflow sets its flag but leaves `rst_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_en | input | 1 | One-cycle pulse per slow-clock period |
| dbg_halt | input | 1 | Debugger halt indication |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte address (0x0 command, 0x4 configuration, 0x8 status) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| rst_req | output | 1 | Sticky reset request |
| wdt_err | output | 1 | Underflow or window-error flag pending |

## Verification
The in-module assertions check several rules on every cycle:
- the configuration cannot change once locked;
- the reset request never drops;
- a running step decrements the count by exactly one;
- a step at zero produces an underflow and a reload;
- an early restart sets the window-error flag;
- the count holds still while stopped or frozen by debug.

The bench scenarios cover the rest:
- the exact reset values;
- the prescale ratio;
- that keyless commands and a second configuration write leave no trace;
- that the prescaler is cleared by a restart;
- that the flags clear on read;
- that reset enable gates the request.

// File: rtl/wwdt_core.sv
module wwdt_core #(
  parameter int PRESCALE = 128,
  parameter logic [7:0] KEY = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_en,
  input  logic        dbg_halt,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        rst_req,
  output logic        wdt_err
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
  localparam logic [3:0] A_CMD = 4'h0, A_CFG = 4'h4, A_STS = 4'h8;

  logic [11:0]   reload_q, win_q, cnt_q;
  logic          rsten_q, dfrz_q, stop_q, locked_q;
  logic [PW-1:0] pre_q;
  logic          uf_q, we_q, req_q;

  logic unused_bits;
  assign unused_bits = ^{wr_data[23:1], wr_data[31:27]};

  wire cfg_wr   = wr_en && addr == A_CFG && !locked_q;
  wire cmd_hit  = wr_en && addr == A_CMD && wr_data[31:24] == KEY && wr_data[0];
  wire in_win   = cnt_q <= win_q;
  wire restart  = cmd_hit && in_win;
  wire win_bad  = cmd_hit && !in_win;
  wire run      = !stop_q && !(dfrz_q && dbg_halt);
  wire tick     = run && slow_en && pre_q == PRE_LAST;
  wire uflow    = tick && cnt_q == 12'd0 && !restart && !cfg_wr;
  wire sts_rd   = rd_en && addr == A_STS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= 12'hFFF;
      win_q    <= 12'hFFF;
      rsten_q  <= 1'b1;
      dfrz_q   <= 1'b0;
      stop_q   <= 1'b0;
      locked_q <= 1'b0;
    end else if (cfg_wr) begin
      reload_q <= wr_data[11:0];
      win_q    <= wr_data[23:12];
      rsten_q  <= wr_data[24];
      dfrz_q   <= wr_data[25];
      stop_q   <= wr_data[26];
      locked_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= 12'hFFF;
      pre_q <= '0;
    end else if (cfg_wr) begin
      cnt_q <= wr_data[11:0];
      pre_q <= '0;
    end else if (restart) begin
      cnt_q <= reload_q;
      pre_q <= '0;
    end else if (run && slow_en) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        cnt_q <= (cnt_q == 12'd0) ? reload_q : cnt_q - 12'd1;
      end else begin
        pre_q <= pre_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uf_q  <= 1'b0;
      we_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      uf_q  <= uflow   | (uf_q & ~sts_rd);
      we_q  <= win_bad | (we_q & ~sts_rd);
      req_q <= req_q | (rsten_q & (uflow | win_bad));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      case (addr)
        A_CFG:   rd_data <= {5'd0, stop_q, dfrz_q, rsten_q, win_q, reload_q};
        A_STS:   rd_data <= {4'd0, cnt_q, 14'd0, we_q, uf_q};
        default: rd_data <= '0;
      endcase
    end
  end

  assign rst_req = req_q;
  assign wdt_err = uf_q | we_q;

  assert_mode_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable({reload_q, win_q, rsten_q, dfrz_q, stop_q}));

  assert_req_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != 12'd0 && !cmd_hit && !cfg_wr) |=> cnt_q == $past(cnt_q) - 12'd1);

  assert_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |=> (uf_q && cnt_q == $past(reload_q)));

  assert_early_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_bad |=> (we_q && cnt_q == $past(cnt_q)));

  assert_stop_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !cmd_hit && !cfg_wr) |=> ($stable(cnt_q) && !$rose(uf_q)));

  assert_debug_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dfrz_q && dbg_halt && !cmd_hit && !cfg_wr) |=> $stable({cnt_q, pre_q}));
endmodule

// File: tb/wwdt_core_test.sv
module wwdt_core_test;
  localparam int P = 4;
  logic clk = 0, rst_n = 0, slow_en = 0, dbg_halt = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic rst_req, wdt_err;
  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  wwdt_core #(.PRESCALE(P)) uut (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .dbg_halt(dbg_halt),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .rst_req(rst_req), .wdt_err(wdt_err));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; dbg_halt = 0;
    repeat (2) @(negedge clk); rst_n = 1;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_en = 1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_en = 1;
      @(negedge clk); slow_en = 0;
    end
  endtask

  always begin
    @(posedge clk);
    if (rd_en) begin
      @(negedge clk);
      if (exp_q.size() == 0) check("scoreboard underrun", 32'd1, 32'd0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog timeout", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset values
    bus_read(4'h4, 32'h01FF_FFFF, "R1 config reset");
    bus_read(4'h8, 32'h0FFF_0000, "R1 status reset");
    check("R1 rst_req low", {31'd0, rst_req}, 0);
    check("R1 wdt_err low", {31'd0, wdt_err}, 0);
    // R2 prescale
    pulses(P);
    pulses(P - 1);
    bus_read(4'h8, 32'h0FFE_0000, "R2 one step per PRESCALE");
    pulses(1);
    bus_read(4'h8, 32'h0FFD_0000, "R2 second step");
    // R5 restart clears prescaler, window 0xFFF accepts any count
    pulses(2);
    bus_write(4'h0, 32'hA500_0001);
    bus_read(4'h8, 32'h0FFF_0000, "R5 restart reload");
    pulses(P - 1);
    bus_read(4'h8, 32'h0FFF_0000, "R5 prescaler cleared");
    pulses(1);
    bus_read(4'h8, 32'h0FFE_0000, "R5 step after restart");
    // R6 bad key / missing bit
    bus_write(4'h0, 32'h5A00_0001);
    bus_read(4'h8, 32'h0FFE_0000, "R6 wrong key ignored");
    bus_write(4'h0, 32'hA500_0000);
    bus_read(4'h8, 32'h0FFE_0000, "R6 bit0 clear ignored");
    // R4 write-once
    bus_write(4'h4, 32'h0100_3005);
    bus_read(4'h4, 32'h0100_3005, "R4 first config stored");
    bus_read(4'h8, 32'h0005_0000, "R4 count loaded");
    bus_write(4'h4, 32'h0000_0007);
    bus_read(4'h4, 32'h0100_3005, "R4 second config ignored");
    bus_read(4'h8, 32'h0005_0000, "R4 count untouched");
    // R7 early restart
    bus_write(4'h0, 32'hA500_0001);
    check("R7 rst_req raised", {31'd0, rst_req}, 1);
    check("R10 wdt_err set", {31'd0, wdt_err}, 1);
    bus_read(4'h8, 32'h0005_0002, "R7 window flag, no reload");
    bus_read(4'h8, 32'h0005_0000, "R10 flags cleared on read");
    check("R10 wdt_err cleared", {31'd0, wdt_err}, 0);
    check("R3 rst_req sticky", {31'd0, rst_req}, 1);

    // R11 underflow with reset disabled
    do_reset();
    bus_write(4'h4, 32'h00FF_F002);
    pulses(2 * P);
    bus_read(4'h8, 32'h0000_0000, "R2 count reached zero");
    pulses(P);
    check("R11 no rst_req", {31'd0, rst_req}, 0);
    check("R10 wdt_err on underflow", {31'd0, wdt_err}, 1);
    bus_read(4'h8, 32'h0002_0001, "R3 underflow flag and reload");

    // R8 debug freeze, then R3 underflow with reset request
    do_reset();
    bus_write(4'h4, 32'h03FF_F003);
    dbg_halt = 1;
    pulses(2 * P);
    bus_read(4'h8, 32'h0003_0000, "R8 frozen in debug");
    dbg_halt = 0;
    pulses(P);
    bus_read(4'h8, 32'h0002_0000, "R8 runs after release");
    pulses(3 * P);
    check("R3 rst_req on underflow", {31'd0, rst_req}, 1);
    bus_read(4'h8, 32'h0003_0001, "R3 reload after underflow");

    // R9 stop bit
    do_reset();
    bus_write(4'h4, 32'h05FF_F001);
    pulses(5 * P);
    bus_read(4'h8, 32'h0001_0000, "R9 stopped count");
    check("R9 no rst_req", {31'd0, rst_req}, 0);

    // R5 restart at the window edge
    do_reset();
    bus_write(4'h4, 32'h0100_4006);
    pulses(2 * P);
    bus_read(4'h8, 32'h0004_0000, "R5 count at window");
    bus_write(4'h0, 32'hA500_0001);
    bus_read(4'h8, 32'h0006_0000, "R5 accepted at window edge");
    check("R5 no rst_req", {31'd0, rst_req}, 0);

    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule